// File: doc/BRIEF.md
# Double-Precision Category Classifier

This block examines one 64-bit IEEE-754 double and reports whether it belongs to any of up to eight categories chosen by an 8-bit select mask. The categories cover quiet and signalling NaN, both signed zeros, both signed infinities, denormals, and negative finite values. A flush control makes denormal inputs count as zeros. The individual category hits are gated by their select bits and OR-combined into a single boolean.

The boolean is placed in bit 0 of a parameter-wide mask word. All higher bits are always zero. A write-mask feature can force bit 0 to zero. The word is registered and comes out one cycle after the request, together with a one-cycle valid strobe. A 4-bit reserved field must read all ones. If it does not, the block sets a fault flag and returns an all-zero word in place of a result.

Top module: `fcls_top`

## Requirements
- R1: After a cycle with `rst_n` low, `res_valid`, `res_mask` and `res_illegal` are all zero.
- R2: A request accepted with `req_valid` high at a rising edge produces `res_valid` high after that edge for exactly one cycle. With no request, `res_valid` is low.
- R3: Input fields are decoded as follows. The sign is bit 63 and the exponent is bits 62:52. The exponent counts as all ones at 0x7FF and as zero at 0. The mantissa is bits 51:0.
- R4: Select bit assignment is: bit0 quiet NaN, bit1 +0, bit2 −0, bit3 +infinity, bit4 −infinity, bit5 denormal, bit6 finite negative, bit7 signalling NaN. `res_mask[0]` is the OR over all categories of (hit AND its select bit).
- R5: A NaN has an all-ones exponent and a nonzero mantissa. Mantissa bit 51 set makes it quiet; bit 51 clear makes it signalling.
- R6: With `daz` high, a zero exponent makes the mantissa count as zero. A denormal then classifies as a signed zero and not as a denormal.
- R7: Finite negative means the sign is set, the exponent is not all ones, and the value is not zero. This includes negative denormals when `daz` is low.
- R8: When `wm_en` is high and `wm_bit` is low, `res_mask[0]` is 0 whatever the class. When `wm_en` is low, `wm_bit` has no effect.
- R9: `res_mask` bits above bit 0 are always zero.
- R10: When `rsvd` differs from 4'b1111, `res_illegal` is high with the strobe and `res_mask` is all zero. Otherwise `res_illegal` is low with the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| operand | input | 64 | Double-precision value to classify |
| cat_sel | input | 8 | Category select mask |
| daz | input | 1 | Treat denormals as zero |
| wm_en | input | 1 | Write-mask enable |
| wm_bit | input | 1 | Write-mask bit |
| rsvd | input | 4 | Reserved field, must be 4'b1111 |
| res_valid | output | 1 | One-cycle result strobe |
| res_mask | output | MASK_W | Result mask word |
| res_illegal | output | 1 | Illegal-encoding flag |

## Verification
The assertions assume that the inputs are known (not X) whenever `req_valid` is high. They also assume that `req_valid` may be high on consecutive cycles, with each request independent of the others. The checker compares registered outputs against the inputs captured one cycle earlier, so it needs no limit on the request rate. The stimulus drives every input to a defined value on every cycle. It gives the reserved field its legal value most of the time, so that classification results are exercised often.

// File: rtl/fcls_pkg.sv
// Package: shared field widths and category bit positions for the classifier.
package fcls_pkg;
    localparam int FP_W   = 64;
    localparam int EXP_W  = 11;
    localparam int MAN_W  = 52;
    localparam int CAT_N  = 8;
    localparam int RSV_W  = 4;

    // Category index; position matches the select-mask bit it is gated by.
    typedef enum int unsigned {
        CAT_QNAN  = 0,
        CAT_PZERO = 1,
        CAT_NZERO = 2,
        CAT_PINF  = 3,
        CAT_NINF  = 4,
        CAT_DENRM = 5,
        CAT_FNEG  = 6,
        CAT_SNAN  = 7
    } cat_idx_e;

    // Decoded view of one operand.
    typedef struct packed {
        logic sign;
        logic exp_ones;
        logic exp_zero;
        logic man_zero;
        logic quiet_bit;
    } fp_fields_t;
endpackage

// File: rtl/fcls_decode.sv
// Module: fcls_decode
// Splits a double into sign, exponent and mantissa, and reduces them to the
// flags the category tests need. Assumes binary64 layout. When daz is set,
// a zero exponent makes the mantissa count as zero.
module fcls_decode
    import fcls_pkg::*;
(
    input  logic [FP_W-1:0] operand,
    input  logic            daz,
    output fp_fields_t      fields
);
    localparam int MAN_MSB = MAN_W - 1;
    localparam int EXP_LSB = MAN_W;
    localparam int EXP_MSB = MAN_W + EXP_W - 1;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    // Purpose: slice and reduce the operand fields.
    always_comb begin
        exp_f            = operand[EXP_MSB:EXP_LSB];
        man_f            = operand[MAN_MSB:0];
        fields.sign      = operand[FP_W-1];
        fields.exp_ones  = &exp_f;
        fields.exp_zero  = ~|exp_f;
        fields.man_zero  = (fields.exp_zero && daz) || (~|man_f);
        fields.quiet_bit = man_f[MAN_MSB];
    end
endmodule

// File: rtl/fcls_cats.sv
// Module: fcls_cats
// Produces one hit bit per category from decoded fields, then gates each with
// its select bit and OR-reduces. Assumes fields come from fcls_decode.
module fcls_cats
    import fcls_pkg::*;
(
    input  fp_fields_t       fields,
    input  logic [CAT_N-1:0] cat_sel,
    output logic [CAT_N-1:0] hits,
    output logic             match
);
    logic is_zero;
    logic is_nan;
    logic is_inf;

    // Purpose: evaluate the eight category tests.
    always_comb begin
        is_zero = fields.exp_zero && fields.man_zero;
        is_nan  = fields.exp_ones && !fields.man_zero;
        is_inf  = fields.exp_ones && fields.man_zero;
        hits            = '0;
        hits[CAT_QNAN]  = is_nan && fields.quiet_bit;
        hits[CAT_SNAN]  = is_nan && !fields.quiet_bit;
        hits[CAT_PZERO] = is_zero && !fields.sign;
        hits[CAT_NZERO] = is_zero && fields.sign;
        hits[CAT_PINF]  = is_inf && !fields.sign;
        hits[CAT_NINF]  = is_inf && fields.sign;
        hits[CAT_DENRM] = fields.exp_zero && !fields.man_zero;
        hits[CAT_FNEG]  = fields.sign && !fields.exp_ones && !is_zero;
    end

    logic [CAT_N-1:0] gated;
    for (genvar g = 0; g < CAT_N; g++) begin : g_gate
        assign gated[g] = hits[g] & cat_sel[g];
    end

    // Purpose: combine the selected hits into one boolean.
    always_comb match = |gated;
endmodule

// File: rtl/fcls_out.sv
// Module: fcls_out
// Output stage: applies zeroing write-mask and the reserved-field check, then
// registers the mask word, strobe and fault flag. Synchronous active-low reset.
module fcls_out
    import fcls_pkg::*;
#(
    parameter int MASK_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              match,
    input  logic              wm_en,
    input  logic              wm_bit,
    input  logic [RSV_W-1:0]  rsvd,
    output logic              res_valid,
    output logic [MASK_W-1:0] res_mask,
    output logic              res_illegal
);
    logic bad_enc;
    logic bit0_nxt;

    // Purpose: decide the fault and the final result bit.
    always_comb begin
        bad_enc  = (rsvd != {RSV_W{1'b1}});
        bit0_nxt = match && !(wm_en && !wm_bit) && !bad_enc;
    end

    // Purpose: register the outputs; only bit 0 is ever loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_mask    <= '0;
            res_illegal <= 1'b0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_mask    <= {{(MASK_W-1){1'b0}}, bit0_nxt};
                res_illegal <= bad_enc;
            end else begin
                res_mask    <= '0;
                res_illegal <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fcls_top.sv
// Module: fcls_top
// Classifies one double against selected categories and returns a registered
// mask word one cycle after req_valid. Assumes inputs are stable at the edge.
module fcls_top
    import fcls_pkg::*;
#(
    parameter int MASK_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [63:0]       operand,
    input  logic [7:0]        cat_sel,
    input  logic              daz,
    input  logic              wm_en,
    input  logic              wm_bit,
    input  logic [3:0]        rsvd,
    output logic              res_valid,
    output logic [MASK_W-1:0] res_mask,
    output logic              res_illegal
);
    fp_fields_t       fields;
    logic [CAT_N-1:0] hits;
    logic             match;

    fcls_decode u_dec (
        .operand (operand),
        .daz     (daz),
        .fields  (fields)
    );

    fcls_cats u_cat (
        .fields  (fields),
        .cat_sel (cat_sel),
        .hits    (hits),
        .match   (match)
    );

    fcls_out #(.MASK_W(MASK_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .match       (match),
        .wm_en       (wm_en),
        .wm_bit      (wm_bit),
        .rsvd        (rsvd),
        .res_valid   (res_valid),
        .res_mask    (res_mask),
        .res_illegal (res_illegal)
    );
endmodule

// File: rtl/fcls_checker.sv
// Module: fcls_checker
// Temporal checks on the classifier ports; bound into fcls_top.
module fcls_checker #(
    parameter int MASK_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [63:0]       operand,
    input logic [7:0]        cat_sel,
    input logic              wm_en,
    input logic              wm_bit,
    input logic [3:0]        rsvd,
    input logic              res_valid,
    input logic [MASK_W-1:0] res_mask,
    input logic              res_illegal
);
    logic seen_rst;
    // Purpose: mark that a reset cycle has happened so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
        else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
    end

    p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        req_valid |=> res_valid);
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        !req_valid |=> !res_valid);
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_mask >> 1) == '0);
    p_wm_zero_r8: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        (req_valid && wm_en && !wm_bit) |=> !res_mask[0]);
    p_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        (req_valid && rsvd != 4'hF) |=> (res_illegal && res_mask == '0));
    p_legal_r10: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        (req_valid && rsvd == 4'hF) |=> !res_illegal);
    p_nosel_r4: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        (req_valid && cat_sel == 8'h00) |=> !res_mask[0]);
    p_pinf_r4: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        (req_valid && operand == 64'h7FF0_0000_0000_0000 && cat_sel[3] && !wm_en && rsvd == 4'hF)
        |=> res_mask[0]);
endmodule

bind fcls_top fcls_checker #(.MASK_W(MASK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .operand     (operand),
    .cat_sel     (cat_sel),
    .wm_en       (wm_en),
    .wm_bit      (wm_bit),
    .rsvd        (rsvd),
    .res_valid   (res_valid),
    .res_mask    (res_mask),
    .res_illegal (res_illegal)
);

// File: tb/sim_fcls_top.sv
module sim_fcls_top;
    localparam int MASK_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [63:0]       operand = '0;
    logic [7:0]        cat_sel = '0;
    logic              daz = 1'b0;
    logic              wm_en = 1'b0;
    logic              wm_bit = 1'b0;
    logic [3:0]        rsvd = 4'hF;
    logic              res_valid;
    logic [MASK_W-1:0] res_mask;
    logic              res_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fcls_top #(.MASK_W(MASK_W)) u0 (.*);

    // Reference category vector built from R3..R7.
    function automatic logic [7:0] ref_hits(input logic [63:0] v, input logic d);
        logic s, eo, ez, mz, zr;
        logic [7:0] h;
        s  = v[63];
        eo = (v[62:52] == 11'h7FF);
        ez = (v[62:52] == 11'h000);
        mz = (v[51:0] == 52'd0) || (ez && d);
        zr = ez && mz;
        h = '0;
        h[0] = eo && !mz && v[51];
        h[7] = eo && !mz && !v[51];
        h[1] = zr && !s;
        h[2] = zr && s;
        h[3] = eo && mz && !s;
        h[4] = eo && mz && s;
        h[5] = ez && !mz;
        h[6] = s && !eo && !zr;
        return h;
    endfunction

    function automatic logic ref_bit(input logic [63:0] v, input logic [7:0] sel,
                                     input logic d, input logic we, input logic wb,
                                     input logic [3:0] rs);
        if (rs != 4'hF) return 1'b0;
        if (we && !wb) return 1'b0;
        return |(ref_hits(v, d) & sel);
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one request, then sample after the result edge.
    task automatic run(input string req, input logic [63:0] v, input logic [7:0] sel,
                       input logic d, input logic we, input logic wb, input logic [3:0] rs);
        logic e;
        @(negedge clk);
        operand = v; cat_sel = sel; daz = d; wm_en = we; wm_bit = wb; rsvd = rs;
        req_valid = 1'b1;
        e = ref_bit(v, sel, d, we, wb, rs);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid R2"}, 128'(res_valid), 128'(1'b1));
        check({req, " mask R9"}, 128'(res_mask), 128'({{(MASK_W-1){1'b0}}, e}));
        check({req, " illegal R10"}, 128'(res_illegal), 128'(rs != 4'hF));
        @(negedge clk);
        check({req, " one-cycle R2"}, 128'(res_valid), 128'(1'b0));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 valid", 128'(res_valid), 128'(1'b0));
        check("R1 mask", 128'(res_mask), 128'(0));
        check("R1 illegal", 128'(res_illegal), 128'(1'b0));
        rst_n = 1'b1;
        // Directed corners
        run("R4 +0", 64'h0000_0000_0000_0000, 8'h02, 0, 0, 0, 4'hF);
        run("R4 -0", 64'h8000_0000_0000_0000, 8'h04, 0, 0, 0, 4'hF);
        run("R4 +0 wrong sel", 64'h0, 8'hFD, 0, 0, 0, 4'hF);
        run("R3 +inf", 64'h7FF0_0000_0000_0000, 8'h08, 0, 0, 0, 4'hF);
        run("R3 -inf", 64'hFFF0_0000_0000_0000, 8'h10, 0, 0, 0, 4'hF);
        run("R5 qnan", 64'h7FF8_0000_0000_0000, 8'h01, 0, 0, 0, 4'hF);
        run("R5 snan", 64'h7FF0_0000_0000_0001, 8'h80, 0, 0, 0, 4'hF);
        run("R5 snan not quiet", 64'h7FF0_0000_0000_0001, 8'h01, 0, 0, 0, 4'hF);
        run("R6 denorm", 64'h0000_0000_0000_0001, 8'h20, 0, 0, 0, 4'hF);
        run("R6 daz denorm", 64'h0000_0000_0000_0001, 8'h20, 1, 0, 0, 4'hF);
        run("R6 daz zero", 64'h0000_0000_0000_0001, 8'h02, 1, 0, 0, 4'hF);
        run("R7 neg denorm", 64'h8000_0000_0000_0001, 8'h40, 0, 0, 0, 4'hF);
        run("R7 neg denorm daz", 64'h8000_0000_0000_0001, 8'h40, 1, 0, 0, 4'hF);
        run("R7 -1.0", 64'hBFF0_0000_0000_0000, 8'h40, 0, 0, 0, 4'hF);
        run("R7 -inf not fneg", 64'hFFF0_0000_0000_0000, 8'h40, 0, 0, 0, 4'hF);
        run("R8 masked", 64'hBFF0_0000_0000_0000, 8'hFF, 0, 1, 0, 4'hF);
        run("R8 passed", 64'hBFF0_0000_0000_0000, 8'hFF, 0, 1, 1, 4'hF);
        run("R8 wm off", 64'hBFF0_0000_0000_0000, 8'hFF, 0, 0, 0, 4'hF);
        run("R10 bad", 64'hBFF0_0000_0000_0000, 8'hFF, 0, 0, 0, 4'hE);
        run("R10 bad zero", 64'h0, 8'hFF, 0, 0, 0, 4'h0);
        // Random mix, biased towards special exponents
        for (int i = 0; i < 400; i++) begin
            logic [63:0] v;
            logic [3:0] rs;
            v = {$urandom, $urandom};
            case ($urandom_range(0, 3))
                0: v[62:52] = 11'h7FF;
                1: v[62:52] = 11'h000;
                default: ;
            endcase
            if ($urandom_range(0, 3) == 0) v[51:0] = '0;
            rs = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
            run("R4 random", v, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), rs);
        end
        // Back-to-back requests: strobe stays high
        @(negedge clk);
        operand = 64'h0; cat_sel = 8'h02; daz = 0; wm_en = 0; rsvd = 4'hF; req_valid = 1'b1;
        @(negedge clk);
        operand = 64'hFFF0_0000_0000_0000; cat_sel = 8'h02;
        check("R2 b2b first", 128'({res_valid, res_mask[0]}), 128'(2'b11));
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 b2b second", 128'({res_valid, res_mask[0]}), 128'(2'b10));
        @(negedge clk);
        check("R2 idle", 128'(res_valid), 128'(1'b0));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule